// File: doc/BRIEF.md
# Thread Context Run-Control Evaluator

This block keeps, for each hardware thread context, a halt bit, an activated bit and a dynamically-allocatable bit. It also keeps a shared field that sets how many contexts take part in run control. From these it decides which contexts are running. Software changes the state through a single write port. Every accepted write asks for a re-evaluation of run state. That request is not acted on at once. It is deferred by one cycle, and a second write that lands while the request is still waiting is folded into the same evaluation.

When the evaluation fires, all contexts within the configured count are judged in parallel. A context runs exactly when its halt bit is clear and its activated bit is set. A context whose running flag changes emits a one-cycle halt pulse or resume pulse. The block also drives the read-only reset values of the multithreading configuration: the highest context index, the highest virtual-processor index, the context-allocation flag, the master flag and each context's binding identifier.

The update sequencer has two named states. IDLE waits for a write; the transition IDLE to ARMED is taken on any write. ARMED always returns to IDLE on the next edge, and that edge is the evaluation edge. A write accepted on the evaluation edge is merged into the evaluation and does not re-arm the sequencer.

Top module: `tcrc_top`

## Requirements
- R1: After reset, context 0 is running, every other context is stopped, and no halt or resume pulse is asserted.
- R2: After reset, `cfg_tc_max` is NUM_TC-1, `cfg_vpe_max` is NUM_VPE-1, `cfg_tc_alloc` and `vpe_master` are 1, the binding identifier of context i (bits i*TCW upward of `tc_bind_id`) equals i, and `tc_dyn_alloc` is 1 for every context except context 0.
- R3: At an evaluation, each evaluated context's running flag becomes 1 when its halt bit is 0 and its activated bit is 1, and becomes 0 otherwise.
- R4: A write on clock edge k, made while the sequencer is IDLE, leaves the running flags and pulses unchanged at edge k and triggers the evaluation at edge k+1. Between evaluations the running flags do not change.
- R5: A write on the edge that follows an arming write is merged into that evaluation: the evaluation sees both writes, and no further evaluation follows unless a new write arrives.
- R6: Only contexts whose index is at most the thread-count field take part in an evaluation. Other contexts keep their running flag and emit no pulse.
- R7: `tc_halt_pulse[i]` is high for exactly one cycle when context i's running flag goes from 1 to 0, and `tc_resume_pulse[i]` when it goes from 0 to 1. The two pulses are never high together, and neither fires when the flag is unchanged.
- R8: A thread-count write larger than NUM_TC-1 saturates to NUM_TC-1. The stored field is visible on `cfg_tc_max`.
- R9: Write field codes on `wr_field` are: 0 for the halt bit, 1 for the activated bit, 2 for the dynamically-allocatable bit (these three take `wr_data[0]` for context `wr_tc`), and 3 for the thread-count field (takes `wr_data`, ignores `wr_tc`). Every write arms an update, including writes of the allocatable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_field | input | 2 | Field code of the write |
| wr_tc | input | TCW | Target context of a per-context write |
| wr_data | input | TCW | Write data (bit 0 for per-context bits) |
| tc_running | output | NUM_TC | Running flag per context |
| tc_halt_pulse | output | NUM_TC | One-cycle pulse when a context stops |
| tc_resume_pulse | output | NUM_TC | One-cycle pulse when a context starts |
| cfg_tc_max | output | TCW | Thread-count field (highest evaluated index) |
| cfg_vpe_max | output | VPW | Highest virtual-processor index |
| cfg_tc_alloc | output | 1 | Context-allocation capability flag |
| vpe_master | output | 1 | Master virtual-processor flag |
| tc_bind_id | output | NUM_TC*TCW | Binding identifier of each context |
| tc_dyn_alloc | output | NUM_TC | Dynamically-allocatable bit per context |

## Verification
The assertions assume that `wr_field` carries a defined code whenever `wr_en` is high, and that `wr_tc` names an existing context for per-context writes. They also assume that reset is held for at least one clock edge before any write. The stimulus drives inputs only on falling edges and always starts from a held reset. Per-context writes use indices below NUM_TC. Thread-count writes include a value above the legal maximum to exercise saturation. Back-to-back write bursts exercise merging and re-arming without ever leaving a field code undefined.

// File: rtl/tcrc_pkg.sv
package tcrc_pkg;

    typedef enum logic [1:0] {
        FLD_HALT  = 2'd0,
        FLD_ACT   = 2'd1,
        FLD_DYN   = 2'd2,
        FLD_COUNT = 2'd3
    } tcrc_field_e;

    typedef enum logic {
        UPD_IDLE  = 1'b0,
        UPD_ARMED = 1'b1
    } tcrc_upd_e;

endpackage

// File: rtl/tcrc_regs.sv
module tcrc_regs #(
    parameter int NUM_TC = 4,
    parameter int TCW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [TCW-1:0]    wr_tc,
    input  logic [TCW-1:0]    wr_data,
    output logic [NUM_TC-1:0] halt_nx,
    output logic [NUM_TC-1:0] act_nx,
    output logic [NUM_TC-1:0] dyn_q,
    output logic [TCW-1:0]    cnt_nx,
    output logic [TCW-1:0]    cnt_q
);
    import tcrc_pkg::*;

    localparam logic [TCW-1:0]    TC_MAX   = TCW'(NUM_TC - 1);
    localparam logic [NUM_TC-1:0] ACT_RST  = NUM_TC'(1);
    localparam logic [NUM_TC-1:0] DYN_RST  = ~NUM_TC'(1);

    logic [NUM_TC-1:0] halt_q, act_q;
    logic [NUM_TC-1:0] dyn_nx;
    tcrc_field_e       fld;
    logic              tc_ok;

    assign fld   = tcrc_field_e'(wr_field);
    assign tc_ok = (32'(wr_tc) < NUM_TC);

    always_comb begin
        halt_nx = halt_q;
        act_nx  = act_q;
        dyn_nx  = dyn_q;
        cnt_nx  = cnt_q;
        if (wr_en) begin
            unique case (fld)
                FLD_HALT:  if (tc_ok) halt_nx[wr_tc] = wr_data[0];
                FLD_ACT:   if (tc_ok) act_nx[wr_tc]  = wr_data[0];
                FLD_DYN:   if (tc_ok) dyn_nx[wr_tc]  = wr_data[0];
                FLD_COUNT: cnt_nx = (wr_data > TC_MAX) ? TC_MAX : wr_data;
                default:   cnt_nx = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q <= '0;
            act_q  <= ACT_RST;
            dyn_q  <= DYN_RST;
            cnt_q  <= TC_MAX;
        end else begin
            halt_q <= halt_nx;
            act_q  <= act_nx;
            dyn_q  <= dyn_nx;
            cnt_q  <= cnt_nx;
        end
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TC_MAX);

endmodule

// File: rtl/tcrc_fsm.sv
module tcrc_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    output logic eval_fire
);
    import tcrc_pkg::*;

    tcrc_upd_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:  state_d = wr_en ? UPD_ARMED : UPD_IDLE;
            UPD_ARMED: state_d = UPD_IDLE;
            default:   state_d = UPD_IDLE;
        endcase
    end

    always_comb begin
        eval_fire = (state_q == UPD_ARMED);
    end

    // R4
    armed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_ARMED) |-> ($past(wr_en) && $past(state_q) == UPD_IDLE));

    // R5
    armed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_ARMED) |=> (state_q == UPD_IDLE));

endmodule

// File: rtl/tcrc_eval.sv
module tcrc_eval #(
    parameter int NUM_TC = 4,
    parameter int TCW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_fire,
    input  logic [NUM_TC-1:0] halt_nx,
    input  logic [NUM_TC-1:0] act_nx,
    input  logic [TCW-1:0]    cnt_nx,
    output logic [NUM_TC-1:0] running,
    output logic [NUM_TC-1:0] halt_pulse,
    output logic [NUM_TC-1:0] resume_pulse
);

    for (genvar i = 0; i < NUM_TC; i++) begin : g_tc
        localparam logic RST_RUN = (i == 0);
        logic in_scope, want;

        assign in_scope = (TCW'(i) <= cnt_nx);
        assign want     = ~halt_nx[i] & act_nx[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                running[i]      <= RST_RUN;
                halt_pulse[i]   <= 1'b0;
                resume_pulse[i] <= 1'b0;
            end else begin
                halt_pulse[i]   <= 1'b0;
                resume_pulse[i] <= 1'b0;
                if (eval_fire && in_scope) begin
                    running[i]      <= want;
                    halt_pulse[i]   <= running[i] & ~want;
                    resume_pulse[i] <= ~running[i] & want;
                end
            end
        end

        // R7
        halt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            halt_pulse[i] |-> (!running[i] && $past(running[i])));

        // R7
        resume_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            resume_pulse[i] |-> (running[i] && !$past(running[i])));

        // R4
        run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(eval_fire) |-> $stable(running[i]));
    end

endmodule

// File: rtl/tcrc_top.sv
module tcrc_top #(
    parameter int NUM_TC  = 4,
    parameter int NUM_VPE = 2,
    parameter int TCW     = (NUM_TC > 1) ? $clog2(NUM_TC) : 1,
    parameter int VPW     = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_field,
    input  logic [TCW-1:0]        wr_tc,
    input  logic [TCW-1:0]        wr_data,
    output logic [NUM_TC-1:0]     tc_running,
    output logic [NUM_TC-1:0]     tc_halt_pulse,
    output logic [NUM_TC-1:0]     tc_resume_pulse,
    output logic [TCW-1:0]        cfg_tc_max,
    output logic [VPW-1:0]        cfg_vpe_max,
    output logic                  cfg_tc_alloc,
    output logic                  vpe_master,
    output logic [NUM_TC*TCW-1:0] tc_bind_id,
    output logic [NUM_TC-1:0]     tc_dyn_alloc
);

    logic [NUM_TC-1:0] halt_nx, act_nx;
    logic [TCW-1:0]    cnt_nx;
    logic              eval_fire;

    tcrc_regs #(.NUM_TC(NUM_TC), .TCW(TCW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_field (wr_field),
        .wr_tc    (wr_tc),
        .wr_data  (wr_data),
        .halt_nx  (halt_nx),
        .act_nx   (act_nx),
        .dyn_q    (tc_dyn_alloc),
        .cnt_nx   (cnt_nx),
        .cnt_q    (cfg_tc_max)
    );

    tcrc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .eval_fire (eval_fire)
    );

    tcrc_eval #(.NUM_TC(NUM_TC), .TCW(TCW)) u_eval (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval_fire    (eval_fire),
        .halt_nx      (halt_nx),
        .act_nx       (act_nx),
        .cnt_nx       (cnt_nx),
        .running      (tc_running),
        .halt_pulse   (tc_halt_pulse),
        .resume_pulse (tc_resume_pulse)
    );

    assign cfg_vpe_max  = VPW'(NUM_VPE - 1);
    assign cfg_tc_alloc = 1'b1;
    assign vpe_master   = 1'b1;

    for (genvar i = 0; i < NUM_TC; i++) begin : g_bind
        assign tc_bind_id[i*TCW +: TCW] = TCW'(i);
    end

    // R7
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_halt_pulse & tc_resume_pulse) == '0);

    // R4
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tc_halt_pulse | tc_resume_pulse) != '0) |-> $past(wr_en, 2) || $past(wr_en));

endmodule

// File: tb/tcrc_top_bench.sv
module tcrc_top_bench;

    localparam int NT  = 5;
    localparam int NV  = 3;
    localparam int TW  = 3;
    localparam int VW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_field = 2'd0;
    logic [TW-1:0] wr_tc = '0;
    logic [TW-1:0] wr_data = '0;
    logic [NT-1:0] tc_running, tc_halt_pulse, tc_resume_pulse, tc_dyn_alloc;
    logic [TW-1:0] cfg_tc_max;
    logic [VW-1:0] cfg_vpe_max;
    logic          cfg_tc_alloc, vpe_master;
    logic [NT*TW-1:0] tc_bind_id;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tcrc_top #(.NUM_TC(NT), .NUM_VPE(NV)) u_tcrc_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_field        (wr_field),
        .wr_tc           (wr_tc),
        .wr_data         (wr_data),
        .tc_running      (tc_running),
        .tc_halt_pulse   (tc_halt_pulse),
        .tc_resume_pulse (tc_resume_pulse),
        .cfg_tc_max      (cfg_tc_max),
        .cfg_vpe_max     (cfg_vpe_max),
        .cfg_tc_alloc    (cfg_tc_alloc),
        .vpe_master      (vpe_master),
        .tc_bind_id      (tc_bind_id),
        .tc_dyn_alloc    (tc_dyn_alloc)
    );

    // behavioural reference state
    bit  m_halt [NT];
    bit  m_act  [NT];
    bit  m_dyn  [NT];
    bit  m_run  [NT];
    bit  m_hp   [NT];
    bit  m_rp   [NT];
    int  m_cnt;
    bit  m_pend;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) begin
                m_halt[i] = 1'b0;
                m_act[i]  = (i == 0);
                m_dyn[i]  = (i != 0);
                m_run[i]  = (i == 0);
                m_hp[i]   = 1'b0;
                m_rp[i]   = 1'b0;
            end
            m_cnt  = NT - 1;
            m_pend = 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_field)
                    2'd0: m_halt[wr_tc] = wr_data[0];
                    2'd1: m_act[wr_tc]  = wr_data[0];
                    2'd2: m_dyn[wr_tc]  = wr_data[0];
                    default: m_cnt = (int'(wr_data) > NT - 1) ? NT - 1 : int'(wr_data);
                endcase
            end
            for (int i = 0; i < NT; i++) begin
                m_hp[i] = 1'b0;
                m_rp[i] = 1'b0;
            end
            if (m_pend) begin
                for (int i = 0; i < NT; i++) begin
                    if (i <= m_cnt) begin
                        bit want;
                        want = !m_halt[i] && m_act[i];
                        m_hp[i]  = m_run[i] && !want;
                        m_rp[i]  = !m_run[i] && want;
                        m_run[i] = want;
                    end
                end
                m_pend = 1'b0;
            end else if (wr_en) begin
                m_pend = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [NT-1:0] er, eh, ers, ed;
            for (int i = 0; i < NT; i++) begin
                er[i]  = m_run[i];
                eh[i]  = m_hp[i];
                ers[i] = m_rp[i];
                ed[i]  = m_dyn[i];
            end
            chk(tc_running == er, "R3 running flags", int'(tc_running), int'(er));
            chk(tc_halt_pulse == eh, "R7 halt pulses", int'(tc_halt_pulse), int'(eh));
            chk(tc_resume_pulse == ers, "R7 resume pulses", int'(tc_resume_pulse), int'(ers));
            chk(int'(cfg_tc_max) == m_cnt, "R8 thread count field", int'(cfg_tc_max), m_cnt);
            chk(tc_dyn_alloc == ed, "R9 allocatable bits", int'(tc_dyn_alloc), int'(ed));
        end
    end

    task automatic wr(input logic [1:0] f, input int tc, input int d);
        wr_en    = 1'b1;
        wr_field = f;
        wr_tc    = TW'(tc);
        wr_data  = TW'(d);
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset run state
        chk(tc_running == NT'(1), "R1 reset running", int'(tc_running), 1);
        chk((tc_halt_pulse | tc_resume_pulse) == '0, "R1 reset pulses",
            int'(tc_halt_pulse | tc_resume_pulse), 0);
        // R2 reset configuration values
        chk(int'(cfg_tc_max) == NT - 1, "R2 tc max", int'(cfg_tc_max), NT - 1);
        chk(int'(cfg_vpe_max) == NV - 1, "R2 vpe max", int'(cfg_vpe_max), NV - 1);
        chk(cfg_tc_alloc && vpe_master, "R2 alloc/master flags",
            int'({cfg_tc_alloc, vpe_master}), 3);
        for (int i = 0; i < NT; i++)
            chk(int'(tc_bind_id[i*TW +: TW]) == i, "R2 bind id",
                int'(tc_bind_id[i*TW +: TW]), i);
        chk(tc_dyn_alloc == ~NT'(1), "R2 allocatable reset", int'(tc_dyn_alloc), int'(~NT'(1)));

        // R4 deferral: halt context 0
        wr(2'd0, 0, 1);
        chk(tc_running[0] == 1'b1, "R4 no change at write edge", int'(tc_running[0]), 1);
        @(negedge clk);
        chk(tc_running[0] == 1'b0 && tc_halt_pulse[0], "R4 evaluation one edge later",
            int'({tc_running[0], tc_halt_pulse[0]}), 1);
        @(negedge clk);
        chk(tc_halt_pulse == '0, "R7 pulse lasts one cycle", int'(tc_halt_pulse), 0);

        // R3 resume context 1
        wr(2'd1, 1, 1);
        idle(2);

        // R5 merged writes activate two contexts in one evaluation
        wr(2'd1, 2, 1);
        wr(2'd1, 3, 1);
        chk(tc_resume_pulse == NT'(5'b01100), "R5 merged evaluation",
            int'(tc_resume_pulse), 12);
        idle(2);

        // R5 halt then un-halt merged: no change
        wr(2'd0, 2, 1);
        wr(2'd0, 2, 0);
        chk(tc_running[2] && tc_halt_pulse == '0, "R5 merged cancel",
            int'({tc_running[2], tc_halt_pulse}), 32);
        idle(2);

        // R6 count bound
        wr(2'd3, 0, 1);
        idle(1);
        wr(2'd0, 3, 1);
        idle(2);
        chk(tc_running[3] == 1'b1, "R6 out-of-scope context kept", int'(tc_running[3]), 1);
        // R8 saturation, then context 3 evaluated
        wr(2'd3, 0, 7);
        @(negedge clk);
        chk(int'(cfg_tc_max) == NT - 1, "R8 saturated count", int'(cfg_tc_max), NT - 1);
        chk(tc_running[3] == 1'b0 && tc_halt_pulse[3], "R6 back in scope",
            int'({tc_running[3], tc_halt_pulse[3]}), 1);
        idle(1);

        // R9 allocatable write arms an update with no run change
        wr(2'd2, 1, 0);
        idle(2);

        // bursts of back-to-back writes
        for (int k = 0; k < 12; k++) begin
            wr(2'(k % 2), (k % 2 == 0) ? 0 : 4, (k / 2) % 2);
        end
        idle(3);
        for (int k = 0; k < 6; k++) begin
            wr(2'd1, k % NT, k % 2);
            idle(k % 3);
        end
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule